// File: doc/BRIEF.md
# Phase-Staggered Multi-Axis Center-Aligned PWM

This block drives up to five three-phase motor bridges from one clock. Each phase of each axis has a high-side gate and a low-side gate. The two gates of a phase are complementary, and a programmable dead band separates them. Every axis runs a center-aligned waveform over a full cycle of `2*P` clocks, where `P` is the period setting. An up-counter sweeps `0..P-1` twice per full cycle, and a half flag marks the rising and falling halves.

Each axis counter leaves reset preloaded with `n*S`, where `n` is the axis index and `S` is the offset step. Axis `n` therefore runs `n*S` clocks ahead of axis 0. This lets a single converter scan measure the axes one after another. An unshifted trigger timer uses the same period and produces one converter trigger pulse per full cycle. The converter acts on the falling edge of that pulse.

Per-phase duty values arrive through a write port into shadow registers. Each axis copies its shadow values into its active values only at the boundary of its own full cycle. A waveform already in progress is therefore never changed mid-cycle. The configuration inputs (period, step, dead time and the two pre-trigger values) are expected to stay constant while reset is low.

Top module: `stagger_pwm`

## Requirements
- R1: While reset is high, and on its release, every high-side gate, every low-side gate and the trigger are 0, and all duty values read as 0.
- R2: The high-side and low-side gates of one phase are never 1 in the same cycle.
- R3: With duty `D` (where `2*D > T+1`) and dead time `T`, each high-side pulse lasts `2*D - T - 1` clocks.
- R4: Each low-side pulse lasts `2*(P - D) - T - 1` clocks.
- R5: After a high-side gate falls, the low-side gate of the same phase rises exactly `T+1` clocks later. The reverse edge pair has the same gap.
- R6: For equal duty values, every edge of axis `n` occurs `n*S` clocks before the matching edge of axis 0, provided `(NAX-1)*S < P`.
- R7: With `2 <= pre0 <= P-1` and `1 <= pre1 < pre0`, the trigger rises once per full cycle and stays high for `pre0 - pre1` clocks.
- R8: The trigger's falling edge comes exactly `pre1 + D + 1` clocks before the falling edge of the axis-0 high-side gate whose duty is `D` (for `D + 2 < P`).
- R9: A write with the write enable high stores the data into the duty shadow of gate index `a*3 + phase`, which is the same bit index as on the gate buses. The new value shapes the first pulse that begins after the axis next leaves the second half of its cycle. A pulse already under way keeps its old width. Indices of 15 or more are ignored.
- R10: A duty of 0 keeps the high-side gate at 0 and the low-side gate steadily at 1. A duty of `P` or more keeps the high-side gate steadily at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CW | Half-cycle count `P` (full cycle is `2*P`) |
| step_i | input | CW | Per-axis start offset `S` |
| dead_i | input | DW | Dead time `T` |
| pretrig0_i | input | CW | Trigger rise point, counted back from `P` |
| pretrig1_i | input | CW | Trigger fall point, counted back from `P` |
| wr_en_i | input | 1 | Duty write strobe |
| wr_addr_i | input | $clog2(NAX*3) | Gate index `a*3 + phase` |
| wr_data_i | input | CW | Duty value |
| gate_hi_o | output | NAX*3 | High-side gates, bit `a*3 + phase` |
| gate_lo_o | output | NAX*3 | Low-side gates, bit `a*3 + phase` |
| adc_trig_o | output | 1 | Converter trigger pulse |

## Verification
The scoreboard tracks pulse widths on one gate across duty changes, including a write that lands while a pulse is high. A design that loaded shadows at once would shorten or stretch that pulse. The bench measures the rise offsets between axes, so an axis preloaded with the wrong multiple of the step would show a shifted edge. It also measures the trigger's width and its falling-edge position against axis 0, which exposes an off-by-one compare or a trigger placed in the wrong half. The dead-band gap, the zero duty and the full duty are probed directly, and overlap of any complementary pair is counted over the whole run.

// File: rtl/stagger_pwm_pkg.sv
package stagger_pwm_pkg;
  localparam int PHASES = 3;
  typedef enum logic {HALF_UP = 1'b0, HALF_DOWN = 1'b1} half_e;
endpackage

// File: rtl/spwm_deadband.sv
module spwm_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw_i,
  input  logic [DW-1:0] dead_i,
  output logic          hi_o,
  output logic          lo_o
);
  logic          lvl_q;
  logic [DW-1:0] dcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      dcnt_q <= '0;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else if (raw_i != lvl_q) begin
      lvl_q  <= raw_i;
      dcnt_q <= '0;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else if (dcnt_q != dead_i) begin
      dcnt_q <= dcnt_q + 1'b1;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
    end else begin
      hi_o <= lvl_q;
      lo_o <= ~lvl_q;
    end
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(hi_o && lo_o));
  assert_hi_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_o) |-> !$past(lo_o));
  assert_lo_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_o) |-> !$past(hi_o));
endmodule

// File: rtl/spwm_axis.sv
module spwm_axis
  import stagger_pwm_pkg::*;
#(
  parameter int CW   = 12,
  parameter int DW   = 8,
  parameter int AXIS = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        period_i,
  input  logic [CW-1:0]        step_i,
  input  logic [DW-1:0]        dead_i,
  input  logic [PHASES*CW-1:0] duty_i,
  output logic [PHASES-1:0]    hi_o,
  output logic [PHASES-1:0]    lo_o
);
  localparam logic [CW-1:0] AX = CW'(AXIS);

  logic [CW-1:0]     cnt_q;
  half_e             half_q;
  logic              wrap_w;
  logic [CW-1:0]     ramp_w;
  logic [CW-1:0]     duty_act [PHASES];
  logic [PHASES-1:0] raw_q;

  assign wrap_w = (cnt_q >= period_i - 1'b1);
  // Rising half counts the ramp down so pulses straddle the half boundary.
  assign ramp_w = (half_q == HALF_DOWN) ? cnt_q : (period_i - 1'b1 - cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= AX * step_i;
      half_q <= HALF_UP;
    end else if (wrap_w) begin
      cnt_q  <= '0;
      half_q <= (half_q == HALF_UP) ? HALF_DOWN : HALF_UP;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q < period_i);

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst) begin
        duty_act[p] <= '0;
        raw_q[p]    <= 1'b0;
      end else begin
        if (wrap_w && half_q == HALF_DOWN) duty_act[p] <= duty_i[p*CW +: CW];
        raw_q[p] <= (ramp_w < duty_act[p]);
      end
    end

    assert_shadow_load_R9: assert property (@(posedge clk) disable iff (rst)
      !$stable(duty_act[p]) |-> (cnt_q == '0 && half_q == HALF_UP));

    spwm_deadband #(.DW(DW)) u_db (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_q[p]),
      .dead_i(dead_i),
      .hi_o  (hi_o[p]),
      .lo_o  (lo_o[p])
    );
  end
endmodule

// File: rtl/spwm_trigger.sv
module spwm_trigger
  import stagger_pwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] pre0_i,
  input  logic [CW-1:0] pre1_i,
  output logic          trig_o
);
  logic [CW-1:0] cnt_q;
  half_e         half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= HALF_UP;
      trig_o <= 1'b0;
    end else begin
      if (cnt_q >= period_i - 1'b1) begin
        cnt_q  <= '0;
        half_q <= (half_q == HALF_UP) ? HALF_DOWN : HALF_UP;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (half_q == HALF_UP && cnt_q == period_i - pre0_i)      trig_o <= 1'b1;
      else if (half_q == HALF_UP && cnt_q == period_i - pre1_i) trig_o <= 1'b0;
    end
  end

  assert_trig_half_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_o) |-> half_q == HALF_UP);
endmodule

// File: rtl/stagger_pwm.sv
module stagger_pwm
  import stagger_pwm_pkg::*;
#(
  parameter int NAX = 5,
  parameter int CW  = 12,
  parameter int DW  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CW-1:0]              period_i,
  input  logic [CW-1:0]              step_i,
  input  logic [DW-1:0]              dead_i,
  input  logic [CW-1:0]              pretrig0_i,
  input  logic [CW-1:0]              pretrig1_i,
  input  logic                       wr_en_i,
  input  logic [$clog2(NAX*3)-1:0]   wr_addr_i,
  input  logic [CW-1:0]              wr_data_i,
  output logic [NAX*3-1:0]           gate_hi_o,
  output logic [NAX*3-1:0]           gate_lo_o,
  output logic                       adc_trig_o
);
  localparam int NG = NAX * PHASES;

  // Shadows stay in flops: every axis reads all its phases in parallel.
  logic [CW-1:0] shadow_q [NG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NG; i++) shadow_q[i] <= '0;
    end else if (wr_en_i && (int'(wr_addr_i) < NG)) begin
      shadow_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic [PHASES*CW-1:0] duty_w;
    for (genvar p = 0; p < PHASES; p++) begin : g_pack
      assign duty_w[p*CW +: CW] = shadow_q[a*PHASES + p];
    end

    spwm_axis #(.CW(CW), .DW(DW), .AXIS(a)) u_axis (
      .clk     (clk),
      .rst     (rst),
      .period_i(period_i),
      .step_i  (step_i),
      .dead_i  (dead_i),
      .duty_i  (duty_w),
      .hi_o    (gate_hi_o[a*PHASES +: PHASES]),
      .lo_o    (gate_lo_o[a*PHASES +: PHASES])
    );
  end

  spwm_trigger #(.CW(CW)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .period_i(period_i),
    .pre0_i  (pretrig0_i),
    .pre1_i  (pretrig1_i),
    .trig_o  (adc_trig_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (gate_hi_o == '0 && gate_lo_o == '0 && !adc_trig_o));
endmodule

// File: tb/stagger_pwm_bench.sv
`timescale 1ns/1ps
module stagger_pwm_bench;
  localparam int NAX = 5, CW = 12, DW = 8, NG = NAX*3;
  localparam int PER = 64, STEP = 5, DT = 3, PRE0 = 20, PRE1 = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [CW-1:0] period_i = CW'(PER), step_i = CW'(STEP);
  logic [DW-1:0] dead_i = DW'(DT);
  logic [CW-1:0] pre0_i = CW'(PRE0), pre1_i = CW'(PRE1);
  logic wr_en = 1'b0;
  logic [$clog2(NG)-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NG-1:0] gate_hi, gate_lo;
  logic trig;

  stagger_pwm #(.NAX(NAX), .CW(CW), .DW(DW)) u_stagger_pwm (
    .clk(clk), .rst(rst), .period_i(period_i), .step_i(step_i),
    .dead_i(dead_i), .pretrig0_i(pre0_i), .pretrig1_i(pre1_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .adc_trig_o(trig));

  int checks = 0, errors = 0, cyc = 0, overlaps = 0;
  int hi_rise_t[NG], hi_fall_t[NG], lo_rise_t[NG], hi_w[NG], lo_w[NG];
  int hi_rises[NG], hi_falls[NG];
  logic [NG-1:0] hi_prev = '0, lo_prev = '0;
  logic trig_prev = 1'b0;
  int trig_rise_t = 0, trig_fall_t = 0, trig_w = 0, trig_rises = 0;
  int q_w[$];
  string q_tag[$];
  event ev_rise0, ev_fall0;

  initial begin
    for (int i = 0; i < NG; i++) begin
      hi_rise_t[i] = 0; hi_fall_t[i] = 0; lo_rise_t[i] = 0;
      hi_w[i] = 0; lo_w[i] = 0; hi_rises[i] = 0; hi_falls[i] = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr[$clog2(NG)-1:0]; wr_data = data[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: samples away from the active edge, pops the scoreboard.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      overlaps += $countones(gate_hi & gate_lo);
      for (int i = 0; i < NG; i++) begin
        if (gate_lo[i] && !lo_prev[i]) lo_rise_t[i] = cyc;
        if (!gate_lo[i] && lo_prev[i]) lo_w[i] = cyc - lo_rise_t[i];
        if (gate_hi[i] && !hi_prev[i]) begin
          hi_rise_t[i] = cyc; hi_rises[i]++;
          if (i == 0) -> ev_rise0;
        end
        if (!gate_hi[i] && hi_prev[i]) begin
          hi_fall_t[i] = cyc; hi_w[i] = cyc - hi_rise_t[i]; hi_falls[i]++;
          if (i == 0) begin
            if (q_w.size() > 0) begin
              int e; string t;
              e = q_w.pop_front(); t = q_tag.pop_front();
              check(hi_w[0] == e, t, hi_w[0], e);
            end
            -> ev_fall0;
          end
        end
      end
      if (trig && !trig_prev) begin trig_rise_t = cyc; trig_rises++; end
      if (!trig && trig_prev) begin trig_fall_t = cyc; trig_w = cyc - trig_rise_t; end
    end
    hi_prev = gate_hi; lo_prev = gate_lo; trig_prev = trig;
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(gate_hi == '0 && gate_lo == '0 && !trig, "R1 reset outputs",
          int'(gate_hi) + int'(gate_lo) + int'(trig), 0);
    rst = 1'b0;
    for (int a = 0; a < NAX; a++) wr(a*3, 20);
    wr(1, 10);
    wr(2, 0);
    wr(14, PER);
    q_w.push_back(2*20-DT-1); q_tag.push_back("R3 high width D=20 first");
    q_w.push_back(2*20-DT-1); q_tag.push_back("R3 high width D=20 second");
    wait (q_w.size() == 0);
    for (int n = 1; n < NAX; n++)
      check(hi_rise_t[0] - hi_rise_t[n*3] == n*STEP, "R6 axis stagger",
            hi_rise_t[0] - hi_rise_t[n*3], n*STEP);
    check(hi_fall_t[0] - trig_fall_t == PRE1 + 20 + 1, "R8 trigger to axis0 fall",
          hi_fall_t[0] - trig_fall_t, PRE1 + 20 + 1);
    check(trig_w == PRE0 - PRE1, "R7 trigger width", trig_w, PRE0 - PRE1);
    repeat (DT + 3) @(negedge clk);
    check(lo_rise_t[0] - hi_fall_t[0] == DT + 1, "R5 dead gap",
          lo_rise_t[0] - hi_fall_t[0], DT + 1);
    check(lo_w[0] == 2*(PER-20)-DT-1, "R4 low width", lo_w[0], 2*(PER-20)-DT-1);
    check(hi_w[1] == 2*10-DT-1, "R3 phase1 width", hi_w[1], 2*10-DT-1);
    check(hi_rises[2] == 0 && gate_lo[2], "R10 zero duty", hi_rises[2], 0);
    check(gate_hi[14] && hi_falls[14] == 0 && hi_rises[14] == 1, "R10 full duty",
          hi_falls[14], 0);
    begin
      int tr;
      tr = trig_rises;
      @(ev_fall0);
      check(trig_rises - tr == 1, "R7 one trigger per cycle", trig_rises - tr, 1);
    end
    wr(0, 10);
    q_w.push_back(2*10-DT-1); q_tag.push_back("R9 new duty at next cycle");
    @(ev_rise0);
    wr(0, 30);
    q_w.push_back(2*30-DT-1); q_tag.push_back("R9 mid-pulse write deferred");
    wait (q_w.size() == 0);
    check(overlaps == 0, "R2 overlap count", overlaps, 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1-level hang actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule